// File: doc/BRIEF.md
# Receive Output Launch Edge and Polarity Selector

This block sits at the digital edge of one line-interface channel. It holds the output registers for the receive rails and for the serial readback bit, and a single edge-select input decides which clock edge launches each of them. The two clock domains take opposite edges: when the receive side launches on the rising edge of the recovered clock, the serial side launches on the falling edge of the serial clock, and the reverse when the select is low.

When the channel runs with clock recovery bypassed, the receive rails are raw slicer pulses and are not retimed. In that mode the same select input sets the polarity of the rails instead: high keeps them active high and low inverts them. The block also samples the serial data input and the transmit rails, whose edges and polarity are fixed whatever the select.

The edge select and the mode flag are captured only while the synchronous reset is held. A change therefore takes effect at the next reset of the output stage, and no shortened pulse can appear at a launch register.

Top module: `rx_edge_pol_sel`

## Requirements
- R1: With the captured edge select high and clock recovery in use, each receive rail output takes the rail input value at a rising edge of `rclk` and changes at no other time.
- R2: With the captured edge select low and clock recovery in use, each receive rail output takes the rail input value at a falling edge of `rclk` and changes at no other time.
- R3: `sdo` takes `sdo_bit` at a falling edge of `sclk` when the captured edge select is high, and at a rising edge of `sclk` when it is low.
- R4: In clock-recovery mode, `rx_out` and `sdo` are active high: a 1 at the input appears as a 1 at the output, for both values of the edge select.
- R5: With `raw_mode` captured high, `rx_out` follows `rx_rail` with no register in the path, equal to `rx_rail` when the captured edge select is high and to its bitwise inverse when it is low.
- R6: `sdi_q` takes `sdi` unchanged at each rising edge of `sclk`, for both values of the edge select.
- R7: `tx_q` takes `tx_rail` unchanged at each falling edge of `tclk`, for both values of the edge select and the mode flag.
- R8: While `srst` is held, `sdo`, `sdi_q`, `tx_q` and the retimed `rx_out` are 0; in raw mode `rx_out` is held at its inactive level, all zeros for active high and all ones for active low.
- R9: `edge_sel` and `raw_mode` are captured only on clock edges where `srst` is high; changing them while `srst` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Recovered receive clock |
| sclk | input | 1 | Serial control clock |
| tclk | input | 1 | Transmit clock |
| srst | input | 1 | Synchronous reset, active high, sampled in every domain |
| edge_sel | input | 1 | Edge select, or raw-mode polarity select |
| raw_mode | input | 1 | 1 selects raw slicer output with clock recovery bypassed |
| rx_rail | input | RAIL_W | Receive rails (data and violation, or raw slicer pulses) |
| sdo_bit | input | 1 | Serial readback bit to launch |
| sdi | input | 1 | Serial data input |
| tx_rail | input | RAIL_W | Transmit data rails |
| rx_out | output | RAIL_W | Launched or polarity-adjusted receive rails |
| sdo | output | 1 | Launched serial data out |
| sdi_q | output | 1 | Sampled serial data input |
| tx_q | output | RAIL_W | Sampled transmit rails |

## Verification
The bench builds the block with its defaults: two rails and the raw path present. All three clocks share one bench clock, so a single input change can be observed before the falling edge, between the edges and after the next rising edge. That separates rising from falling launch in both domains. With six input bits, every input pattern is applied under each of the four combinations of edge select and mode. While each run is active, the select and mode inputs are held at the opposite values, which shows that they are captured only under reset.

// File: rtl/rxp_pkg.sv
package rxp_pkg;
   typedef enum logic {
      LAUNCH_FALL = 1'b0,
      LAUNCH_RISE = 1'b1
   } launch_edge_e;
endpackage

// File: rtl/rxp_cfg_hold.sv
module rxp_cfg_hold #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         srst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   // configuration is only taken while reset is asserted
   always_ff @(posedge clk) begin
      if (srst) q <= d;
   end
endmodule

// File: rtl/rxp_edge_launch.sv
module rxp_edge_launch
   import rxp_pkg::*;
#(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         srst,
   input  launch_edge_e launch,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] q_rise;
   logic [W-1:0] q_fall;

   always_ff @(posedge clk) begin
      if (srst) q_rise <= '0;
      else      q_rise <= d;
   end

   always_ff @(negedge clk) begin
      if (srst) q_fall <= '0;
      else      q_fall <= d;
   end

   // launch is static between resets, so the select never glitches
   assign q = (launch == LAUNCH_RISE) ? q_rise : q_fall;
endmodule

// File: rtl/rxp_raw_slice.sv
module rxp_raw_slice #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         active_high,
   input  logic [W-1:0] rails,
   output logic [W-1:0] q
);
   logic         in_rst;
   logic [W-1:0] flip;

   always_ff @(posedge clk) begin
      in_rst <= srst;
   end

   assign flip = {W{~active_high}};
   assign q    = in_rst ? flip : (rails ^ flip);
endmodule

// File: rtl/rx_edge_pol_sel.sv
module rx_edge_pol_sel
   import rxp_pkg::*;
#(
   parameter int RAIL_W = 2,
   parameter bit RAW_EN = 1'b1
) (
   input  logic              rclk,
   input  logic              sclk,
   input  logic              tclk,
   input  logic              srst,
   input  logic              edge_sel,
   input  logic              raw_mode,
   input  logic [RAIL_W-1:0] rx_rail,
   input  logic              sdo_bit,
   input  logic              sdi,
   input  logic [RAIL_W-1:0] tx_rail,
   output logic [RAIL_W-1:0] rx_out,
   output logic              sdo,
   output logic              sdi_q,
   output logic [RAIL_W-1:0] tx_q
);
   localparam int CFG_W = 2;

   if (RAIL_W < 1 || RAIL_W > 8) begin : g_bad_width
      $error("rx_edge_pol_sel: RAIL_W must lie in 1..8");
   end

   logic [CFG_W-1:0] cfg_r;
   logic             cfg_edge_r;
   logic             cfg_raw;
   logic             cfg_edge_s;
   logic [RAIL_W-1:0] rx_launched;

   // receive-domain configuration
   rxp_cfg_hold #(.W(CFG_W)) u_cfg_r (
      .clk (rclk),
      .srst(srst),
      .d   ({raw_mode, edge_sel}),
      .q   (cfg_r)
   );
   assign cfg_edge_r = cfg_r[0];

   // serial-domain configuration
   rxp_cfg_hold #(.W(1)) u_cfg_s (
      .clk (sclk),
      .srst(srst),
      .d   (edge_sel),
      .q   (cfg_edge_s)
   );

   rxp_edge_launch #(.W(RAIL_W)) u_rx_launch (
      .clk   (rclk),
      .srst  (srst),
      .launch(cfg_edge_r ? LAUNCH_RISE : LAUNCH_FALL),
      .d     (rx_rail),
      .q     (rx_launched)
   );

   // serial side takes the opposite edge
   rxp_edge_launch #(.W(1)) u_sdo_launch (
      .clk   (sclk),
      .srst  (srst),
      .launch(cfg_edge_s ? LAUNCH_FALL : LAUNCH_RISE),
      .d     (sdo_bit),
      .q     (sdo)
   );

   if (RAW_EN) begin : g_raw
      logic [RAIL_W-1:0] raw_q;
      assign cfg_raw = cfg_r[1];
      rxp_raw_slice #(.W(RAIL_W)) u_raw (
         .clk        (rclk),
         .srst       (srst),
         .active_high(cfg_edge_r),
         .rails      (rx_rail),
         .q          (raw_q)
      );
      assign rx_out = cfg_raw ? raw_q : rx_launched;
   end else begin : g_noraw
      logic unused_raw;
      assign unused_raw = cfg_r[1];
      assign cfg_raw    = 1'b0;
      assign rx_out     = rx_launched;
   end

   // serial input: fixed rising edge, active high
   always_ff @(posedge sclk) begin
      if (srst) sdi_q <= 1'b0;
      else      sdi_q <= sdi;
   end

   // transmit rails: fixed falling edge, active high
   always_ff @(negedge tclk) begin
      if (srst) tx_q <= '0;
      else      tx_q <= tx_rail;
   end
endmodule

// File: rtl/rx_edge_pol_sel_chk.sv
module rx_edge_pol_sel_chk #(
   parameter int RAIL_W = 2
) (
   input logic              rclk,
   input logic              sclk,
   input logic              tclk,
   input logic              srst,
   input logic              cfg_edge_r,
   input logic              cfg_raw,
   input logic              cfg_edge_s,
   input logic [RAIL_W-1:0] rx_rail,
   input logic              sdo_bit,
   input logic              sdi,
   input logic [RAIL_W-1:0] tx_rail,
   input logic [RAIL_W-1:0] rx_out,
   input logic              sdo,
   input logic              sdi_q,
   input logic [RAIL_W-1:0] tx_q
);
   assert_rx_rise_R1: assert property (@(posedge rclk) disable iff (srst)
      (!srst && cfg_edge_r && !cfg_raw) |=> rx_out == $past(rx_rail));

   assert_rx_fall_R2: assert property (@(negedge rclk) disable iff (srst)
      (!srst && !cfg_edge_r && !cfg_raw) |=> rx_out == $past(rx_rail));

   assert_sdo_fall_R3: assert property (@(negedge sclk) disable iff (srst)
      (!srst && cfg_edge_s) |=> sdo == $past(sdo_bit));

   assert_sdo_rise_R3: assert property (@(posedge sclk) disable iff (srst)
      (!srst && !cfg_edge_s) |=> sdo == $past(sdo_bit));

   assert_sdi_rise_R6: assert property (@(posedge sclk) disable iff (srst)
      !srst |=> sdi_q == $past(sdi));

   assert_tx_fall_R7: assert property (@(negedge tclk) disable iff (srst)
      !srst |=> tx_q == $past(tx_rail));

   assert_cfg_hold_R9: assert property (@(posedge rclk) disable iff (srst)
      !srst |=> $stable(cfg_edge_r) && $stable(cfg_raw));
endmodule

bind rx_edge_pol_sel rx_edge_pol_sel_chk #(.RAIL_W(RAIL_W)) u_chk (
   .rclk      (rclk),
   .sclk      (sclk),
   .tclk      (tclk),
   .srst      (srst),
   .cfg_edge_r(cfg_edge_r),
   .cfg_raw   (cfg_raw),
   .cfg_edge_s(cfg_edge_s),
   .rx_rail   (rx_rail),
   .sdo_bit   (sdo_bit),
   .sdi       (sdi),
   .tx_rail   (tx_rail),
   .rx_out    (rx_out),
   .sdo       (sdo),
   .sdi_q     (sdi_q),
   .tx_q      (tx_q)
);

// File: tb/test_rx_edge_pol_sel.sv
`timescale 1ns/100ps
module test_rx_edge_pol_sel;
   localparam int RW = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic srst, edge_sel, raw_mode, sdo_bit, sdi;
   logic [RW-1:0] rx_rail, tx_rail, rx_out, tx_q;
   logic sdo, sdi_q;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   rx_edge_pol_sel #(.RAIL_W(RW), .RAW_EN(1'b1)) i_rx_edge_pol_sel (
      .rclk(clk), .sclk(clk), .tclk(clk), .srst(srst),
      .edge_sel(edge_sel), .raw_mode(raw_mode),
      .rx_rail(rx_rail), .sdo_bit(sdo_bit), .sdi(sdi), .tx_rail(tx_rail),
      .rx_out(rx_out), .sdo(sdo), .sdi_q(sdi_q), .tx_q(tx_q)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
      end
   endtask

   // vector layout: [1:0] rx rails, [2] sdo_bit, [3] sdi, [5:4] tx rails
   task automatic drive(input int v);
      rx_rail = v[1:0];
      sdo_bit = v[2];
      sdi     = v[3];
      tx_rail = v[5:4];
   endtask

   // phase 0: before falling edge, 1: between edges, 2: after next rising edge
   task automatic check_phase(input int ph, input bit e, input bit r, input int p, input int n);
      int    rx_e;
      int    inv;
      string rtag;
      inv  = e ? 0 : 3;
      rtag = r ? (e ? "R5 R9 raw active-high" : "R5 R9 raw active-low")
               : (e ? "R1 R4 R9 rx rising" : "R2 R4 R9 rx falling");
      if (r)              rx_e = (n & 3) ^ inv;
      else if (ph == 0)   rx_e = p & 3;
      else if (ph == 1)   rx_e = e ? (p & 3) : (n & 3);
      else                rx_e = n & 3;
      chk(rtag, int'(rx_out), rx_e);
      chk("R3 R4 sdo edge", int'(sdo),
          (ph == 0) ? p[2] : (ph == 1) ? (e ? n[2] : p[2]) : n[2]);
      chk("R6 sdi rising", int'(sdi_q), (ph == 2) ? n[3] : p[3]);
      chk("R7 tx falling", int'(tx_q), (ph == 0) ? ((p >> 4) & 3) : ((n >> 4) & 3));
   endtask

   initial begin
      srst = 1'b1; edge_sel = 1'b0; raw_mode = 1'b0;
      drive(0);
      for (int cfg = 0; cfg < 4; cfg++) begin
         bit e, r;
         int prev;
         e = cfg[0];
         r = cfg[1];
         @(posedge clk); #1;
         srst = 1'b1; edge_sel = e; raw_mode = r;
         drive(0);
         repeat (3) @(posedge clk);
         #0.5;
         // R8: reset levels
         chk("R8 rx reset level", int'(rx_out), (r && !e) ? 3 : 0);
         chk("R8 sdo reset", int'(sdo), 0);
         chk("R8 sdi_q reset", int'(sdi_q), 0);
         chk("R8 tx reset", int'(tx_q), 0);
         #0.5;
         srst = 1'b0;
         edge_sel = ~e;      // R9: must be ignored
         raw_mode = ~r;
         prev = 0;
         for (int v = 0; v < 64; v++) begin
            int nv;
            nv = (v * 37 + cfg * 11) & 63;
            @(posedge clk); #1;
            drive(nv);
            #1;  check_phase(0, e, r, prev, nv);
            #2;  check_phase(1, e, r, prev, nv);
            @(posedge clk); #0.5;
            check_phase(2, e, r, prev, nv);
            prev = nv;
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #500us;
      if (!done) begin
         n_bad++;
         n_vec++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule